// File: doc/BRIEF.md
# Parallel Port FIFO Mode Controller

This block manages the 16-byte transfer queue of a host-side parallel printer port. A host writes to and reads from four small registers. A 3-bit mode field selects how the port behaves. In the three queue modes (automatic output, extended-capability and queue test) the host can fill the queue. In automatic output mode the bytes leave on the eight data pins under a hardware strobe/busy handshake. In test mode the host can read the bytes back without any pin activity.

A service flag, set by hardware, raises an interrupt when the queue needs attention. With the port facing outward this happens when enough space is free; with the port facing inward it happens when enough bytes are waiting. A second interrupt path follows either the peripheral's fault line or its acknowledge line. The mode field will only move between two queue-type modes by way of one of the two plain modes. Entering a plain mode empties the queue.

Top module: `ppfifo_ctrl`

## Requirements
- R1: After reset the mode field is 001, the extended control register reads 0x21, the port control register reads 0x00, `irq` is 0, `pp_strobe_n` is 1 and `pp_data` is 0x00.
- R2: Register select codes are: 0 = queue, 1 = identity register, 2 = extended control (bits 7:5 mode, bit 4 interrupt source, bit 3 reads 0, bit 2 service flag, bit 1 full, bit 0 empty), 3 = port control (bit 5 direction, 1 = inward; bit 4 external interrupt enable). The identity register always reads 0x94, and a write to it leaves it unchanged.
- R3: A write to the extended control register changes the mode only if the old mode or the new mode is 000 or 001. Any other mode change is dropped, while the other writable bits are still written.
- R4: The queue holds 16 bytes. Host writes to select 0 are stored only in modes 010, 011 and 110 and only while the queue is not full. A write to a full queue is dropped. Full reads 1 at 16 bytes and empty reads 1 at 0 bytes.
- R5: While the mode is 000 or 001, the queue is held empty.
- R6: In mode 110, host reads of select 0 return the stored bytes in write order and remove them. `pp_strobe_n` stays 1 and `pp_data` does not change in this mode.
- R7: In mode 010 a byte is sent only while `pp_busy` is 0. The byte appears on `pp_data` while `pp_strobe_n` is held low for exactly STB_CLKS cycles. The next byte waits until `pp_busy` has gone high and then low again. Bytes leave in write order.
- R8: With direction outward in a queue mode, if the service flag is 0 and at least 4 locations are free, hardware sets the flag and raises `irq`.
- R9: With direction inward in a queue mode, the service flag is set and `irq` raised only when at least 12 bytes are held. Free space has no effect in this direction.
- R10: Any write to the extended control register clears a pending service interrupt. Writing 1 to the service flag sets the flag without raising `irq`.
- R11: When port control bit 4 is 1, `irq` also follows the low level of `pp_fault_n` (interrupt source bit 0) or of `pp_ack_n` (interrupt source bit 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_sel | input | 2 | Register select |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host read strobe (pops the queue when selected) |
| host_rdata | output | 8 | Read data for the selected register |
| pp_data | output | 8 | Port data pins |
| pp_strobe_n | output | 1 | Data strobe, active low |
| pp_busy | input | 1 | Peripheral busy, active high |
| pp_fault_n | input | 1 | Peripheral fault, active low |
| pp_ack_n | input | 1 | Peripheral acknowledge, active low |
| irq | output | 1 | Interrupt request, active high |

## Verification
In automatic output mode, a host write that pushes a byte can land in the same cycle as the handshake engine taking the head byte. The occupancy must then stay unchanged and the new byte must join the tail. The bench provokes this by writing bytes at random gaps while a modelled peripheral keeps the engine busy. It judges the outcome by the byte sequence captured at each strobe against the order written, and by the empty flag once all bytes have left.

// File: rtl/ppfifo_ctrl.sv
module ppfifo_ctrl #(
  parameter int DEPTH    = 16,
  parameter int WR_THR   = 4,
  parameter int RD_THR   = 12,
  parameter int STB_CLKS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] host_sel,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  input  logic       host_rd,
  output logic [7:0] host_rdata,
  output logic [7:0] pp_data,
  output logic       pp_strobe_n,
  input  logic       pp_busy,
  input  logic       pp_fault_n,
  input  logic       pp_ack_n,
  output logic       irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = (STB_CLKS > 1) ? $clog2(STB_CLKS + 1) : 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] WR_C    = CW'(WR_THR);
  localparam logic [CW-1:0] RD_C    = CW'(RD_THR);
  localparam logic [7:0]    IDENT   = 8'h94;
  localparam logic [2:0] M_BYTE = 3'b001, M_FOUT = 3'b010, M_ECP = 3'b011, M_TEST = 3'b110;

  typedef enum logic [1:0] {HS_IDLE, HS_STB, HS_WBH, HS_WBL} hs_t;

  logic [2:0]    mode;
  logic          src_ack, svc, svc_irq, dir_in, ext_ie;
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  hs_t           st;
  logic [TW-1:0] tmr;
  logic [7:0]    out_q;

  wire       plain     = (mode <= M_BYTE);
  wire       fifo_mode = (mode == M_FOUT) || (mode == M_ECP) || (mode == M_TEST);
  wire       full      = (cnt == DEPTH_C);
  wire       empty     = (cnt == '0);
  wire       ecr_we    = host_wr && (host_sel == 2'd2);
  wire       ctl_we    = host_wr && (host_sel == 2'd3);
  wire [2:0] new_mode  = host_wdata[7:5];
  wire       mode_ok   = plain || (new_mode <= M_BYTE) || (new_mode == mode);
  wire       push      = host_wr && (host_sel == 2'd0) && fifo_mode && !full;
  wire       host_pop  = host_rd && (host_sel == 2'd0) && (mode == M_TEST) && !empty;
  wire       go        = (st == HS_IDLE) && (mode == M_FOUT) && !empty && !pp_busy;
  wire       pop       = host_pop || go;
  wire       svc_cond  = fifo_mode && (dir_in ? (cnt >= RD_C) : ((DEPTH_C - cnt) >= WR_C));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= M_BYTE;
      src_ack <= 1'b0;
      svc     <= 1'b0;
      svc_irq <= 1'b0;
      dir_in  <= 1'b0;
      ext_ie  <= 1'b0;
    end else begin
      if (ecr_we) begin
        if (mode_ok) mode <= new_mode;
        src_ack <= host_wdata[4];
        svc     <= host_wdata[2];
        svc_irq <= 1'b0;
      end else if (!svc && svc_cond) begin
        svc     <= 1'b1;
        svc_irq <= 1'b1;
      end
      if (ctl_we) begin
        dir_in <= host_wdata[5];
        ext_ie <= host_wdata[4];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (plain) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= HS_IDLE;
      tmr   <= '0;
      out_q <= '0;
    end else begin
      case (st)
        HS_IDLE: if (go) begin
          out_q <= mem[rp];
          tmr   <= TW'(STB_CLKS - 1);
          st    <= HS_STB;
        end
        HS_STB: begin
          if (tmr == '0) st <= HS_WBH;
          else           tmr <= tmr - 1'b1;
        end
        HS_WBH: if (pp_busy)  st <= HS_WBL;
        HS_WBL: if (!pp_busy) st <= HS_IDLE;
        default: st <= HS_IDLE;
      endcase
    end
  end

  assign pp_data     = out_q;
  assign pp_strobe_n = (st != HS_STB);
  assign irq         = svc_irq || (ext_ie && (src_ack ? !pp_ack_n : !pp_fault_n));

  always_comb begin
    case (host_sel)
      2'd0:    host_rdata = mem[rp];
      2'd1:    host_rdata = IDENT;
      2'd2:    host_rdata = {mode, src_ack, 1'b0, svc, full, empty};
      default: host_rdata = {2'b00, dir_in, ext_ie, 4'b0000};
    endcase
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n) cnt <= DEPTH_C)
    else $error("queue occupancy above depth");
  p_mode_rule_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |-> (($past(mode) <= M_BYTE) || (mode <= M_BYTE)))
    else $error("mode moved between two queue modes directly");
  p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n) plain |=> (cnt == '0))
    else $error("queue not empty in a plain mode");
  p_strobe_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pp_strobe_n) |-> $past(!pp_busy))
    else $error("strobe started while peripheral busy");
  p_svc_irq_r10: assert property (@(posedge clk) disable iff (!rst_n) $rose(svc_irq) |-> svc)
    else $error("service interrupt without service flag");
endmodule

// File: tb/ppfifo_ctrl_bench.sv
module ppfifo_ctrl_bench;
  localparam int STB = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, wr, rd, hold_busy, p_busy, fault_n, ack_n;
  logic [1:0] sel;
  logic [7:0] wd;
  wire  [7:0] rdata, pd;
  wire        stb_n, irq;
  wire        busy = hold_busy | p_busy;

  int checks = 0;
  int fails  = 0;
  logic [7:0] sent [32];
  int ns = 0;
  int rx = 0;

  ppfifo_ctrl #(.DEPTH(16), .WR_THR(4), .RD_THR(12), .STB_CLKS(STB)) u_ppfifo_ctrl (
    .clk(clk), .rst_n(rst_n), .host_sel(sel), .host_wr(wr), .host_wdata(wd),
    .host_rd(rd), .host_rdata(rdata), .pp_data(pd), .pp_strobe_n(stb_n),
    .pp_busy(busy), .pp_fault_n(fault_n), .pp_ack_n(ack_n), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); sel = s; wd = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); sel = s; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  function automatic logic [7:0] exp_ecr(input logic [2:0] m, input logic src, input logic sv, input int n);
    return {m, src, 1'b0, sv, (n == 16), (n == 0)};
  endfunction

  // peripheral model: captures each strobed byte, then pulses busy
  initial begin
    int lowcnt;
    logic [7:0] cap;
    lowcnt = 0; cap = '0; p_busy = 1'b0;
    forever begin
      @(negedge clk);
      if (!stb_n) begin
        if (lowcnt == 0) cap = pd;
        lowcnt++;
      end else if (lowcnt != 0) begin
        chk("R7 strobe width", lowcnt, STB);
        chk("R7 byte order", cap, sent[rx]);
        rx++;
        lowcnt = 0;
        p_busy = 1'b1;
        repeat (2) @(negedge clk);
        p_busy = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] q [16];
    int qh, qn, lows, guard;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; sel = '0; wr = 1'b0; rd = 1'b0; wd = '0;
    hold_busy = 1'b1; fault_n = 1'b1; ack_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rreg(2'd2, d); chk("R1 ecr", d, 8'h21);
    rreg(2'd3, d); chk("R1 ctl", d, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 strobe", stb_n, 1);
    chk("R1 data pins", pd, 8'h00);

    // R2 identity register
    rreg(2'd1, d); chk("R2 ident", d, 8'h94);
    wreg(2'd1, 8'h00);
    rreg(2'd1, d); chk("R2 ident after write", d, 8'h94);

    // R3 mode change rule
    wreg(2'd2, 8'hC4); rreg(2'd2, d); chk("R3 001->110", d, 8'hC5);
    wreg(2'd2, 8'h44); rreg(2'd2, d); chk("R3 110->010 dropped", d, 8'hC5);
    wreg(2'd2, 8'h04); rreg(2'd2, d); chk("R3 110->000", d, 8'h05);
    wreg(2'd2, 8'h44); rreg(2'd2, d); chk("R3 000->010", d, 8'h45);
    wreg(2'd2, 8'h74); rreg(2'd2, d); chk("R3 010->011 dropped, source written", d, 8'h55);
    wreg(2'd2, 8'h24); rreg(2'd2, d); chk("R3 010->001", d, 8'h25);

    // R4 / R6 random traffic in test mode against a queue model
    wreg(2'd2, 8'hC4);
    qh = 0; qn = 0;
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 2) begin
        d = 8'($urandom);
        wreg(2'd0, d);
        if (qn < 16) begin q[(qh + qn) % 16] = d; qn++; end
      end else begin
        rreg(2'd0, d);
        if (qn > 0) begin
          chk("R6 read order", d, q[qh]);
          qh = (qh + 1) % 16; qn--;
        end
      end
      rreg(2'd2, d); chk("R4 flags", d, exp_ecr(3'b110, 1'b0, 1'b1, qn));
      chk("R6 strobe quiet", stb_n, 1);
      chk("R6 pins unchanged", pd, 8'h00);
    end
    while (qn > 0) begin
      rreg(2'd0, d); chk("R6 drain order", d, q[qh]);
      qh = (qh + 1) % 16; qn--;
    end

    // R4 overflow: 17th write dropped
    for (int i = 0; i < 17; i++) wreg(2'd0, 8'(8'h30 + i));
    rreg(2'd2, d); chk("R4 full", d, 8'hC6);
    for (int i = 0; i < 16; i++) begin
      rreg(2'd0, d); chk("R4 overflow order", d, 8'(8'h30 + i));
    end
    rreg(2'd2, d); chk("R4 empty", d, 8'hC5);

    // R5 flush on entry to a plain mode
    for (int i = 0; i < 5; i++) wreg(2'd0, 8'(i));
    rreg(2'd2, d); chk("R5 filled", d, 8'hC4);
    wreg(2'd2, 8'h24); rreg(2'd2, d); chk("R5 plain empty", d, 8'h25);
    wreg(2'd2, 8'hC4); rreg(2'd2, d); chk("R5 back empty", d, 8'hC5);

    // R8 outward threshold: 13 held (3 free) then 12 held (4 free)
    for (int i = 0; i < 13; i++) wreg(2'd0, 8'(8'h50 + i));
    wreg(2'd2, 8'hC0);
    repeat (3) @(negedge clk);
    chk("R8 no irq at 3 free", irq, 0);
    rreg(2'd2, d); chk("R8 flag clear at 3 free", d, 8'hC0);
    rreg(2'd0, d);
    repeat (2) @(negedge clk);
    chk("R8 irq at 4 free", irq, 1);
    rreg(2'd2, d); chk("R8 flag set", d, 8'hC4);

    // R10 writing 1 to the flag clears the request and raises nothing
    wreg(2'd2, 8'hC4);
    chk("R10 irq cleared", irq, 0);
    repeat (3) @(negedge clk);
    chk("R10 irq stays low", irq, 0);

    // R9 inward threshold
    wreg(2'd3, 8'h20);
    rreg(2'd0, d);
    wreg(2'd2, 8'hC0);
    repeat (3) @(negedge clk);
    chk("R9 no irq at 11 held", irq, 0);
    wreg(2'd0, 8'hAA);
    repeat (2) @(negedge clk);
    chk("R9 irq at 12 held", irq, 1);
    wreg(2'd2, 8'h24);
    wreg(2'd3, 8'h00);
    chk("R10 plain write clears", irq, 0);

    // R11 external interrupt source
    wreg(2'd3, 8'h10);
    @(negedge clk); fault_n = 1'b0; #1 chk("R11 fault source", irq, 1);
    wreg(2'd2, 8'h34); #1 chk("R11 ack source ignores fault", irq, 0);
    @(negedge clk); ack_n = 1'b0; #1 chk("R11 ack source", irq, 1);
    wreg(2'd3, 8'h00); #1 chk("R11 disabled", irq, 0);
    fault_n = 1'b1; ack_n = 1'b1;
    wreg(2'd2, 8'h24);

    // R7 automatic output with a busy peripheral, then concurrent push/drain
    wreg(2'd2, 8'h44);
    for (int i = 0; i < 6; i++) begin
      sent[ns] = 8'($urandom); ns++;
      wreg(2'd0, sent[ns-1]);
    end
    lows = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!stb_n) lows++;
    end
    chk("R7 held while busy", lows, 0);
    rreg(2'd2, d); chk("R7 bytes kept while busy", d, 8'h44);
    hold_busy = 1'b0;
    for (int i = 0; i < 10; i++) begin
      repeat ($urandom % 4) @(negedge clk);
      sent[ns] = 8'($urandom); ns++;
      wreg(2'd0, sent[ns-1]);
    end
    guard = 0;
    while (rx < 16 && guard < 2000) begin @(negedge clk); guard++; end
    chk("R7 all bytes sent", rx, 16);
    repeat (8) @(negedge clk);
    rreg(2'd2, d); chk("R7 empty after drain", d, 8'h45);
    chk("R7 last byte on pins", pd, sent[15]);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule